// File: doc/BRIEF.md
# Interrupt redirection controller

This block routes a set of edge-signalled interrupt input pins to delivery messages. Each pin owns one redirection entry holding a vector number, a delivery mode, a destination addressing mode, a mask bit and an 8-bit destination. When an unmasked pin sees a rising edge, the block raises a delivery message that carries that entry's fields and the pin number. It holds the message until the consumer accepts it through a valid/ready handshake.

Software reaches the internal registers through two byte offsets on a small register bus. Offset 0x00 holds an 8-bit register index. Offset 0x10 is a 32-bit data window onto whichever register that index names. Every redirection entry is 64 bits wide and takes up two consecutive indices. The block holds an identification register, a read-only version register that reports the table size, an arbitration register that mirrors the identification field, and the redirection table. A typical driver masks every pin, programs the vector and destination of each pin, and then clears the mask bit with a read-modify-write of the low word.

Top module: `irq_route_ctrl`

## Requirements
- R1: A write to byte offset 0x00 stores bits 7:0 of the write data as the register index, and a read of offset 0x00 returns that index in bits 7:0 with all other bits zero.
- R2: Window index 0x00 is the identification register, with only bits 27:24 writable and every other bit reading zero. Window index 0x02 reads the same identification field in bits 27:24 and ignores writes.
- R3: Window index 0x01 is read-only and returns the pin count minus one in bits 23:16 and the constant VERSION (default 0x11) in bits 7:0, with all other bits zero.
- R4: Entry n has its low word at index 0x10+2n and its high word at index 0x10+2n+1. In the low word, bits 7:0 are the vector, bits 10:8 the delivery mode, bit 11 logical (1) or physical (0) addressing, and bit 16 the mask. In the high word, bits 31:24 are the destination. All other bits read as zero.
- R5: After reset the index is 0, the identification field is 0, every entry reads 0x00010000 in its low word and 0 in its high word, and no message is offered.
- R6: A rising edge on an unmasked pin offers a message from the next clock cycle. The message carries the pin number and the entry's vector, mode, addressing bit and destination. The message is withdrawn in the cycle after the handshake completes.
- R7: A rising edge on a masked pin is dropped, and it is not delivered when the pin is later unmasked.
- R8: When several pins are pending, the lowest-numbered pin is offered first, and with ready held high one message completes per cycle in ascending pin order.
- R9: Byte offsets other than 0x00 and 0x10, window indices 0x03 to 0x0F, and indices beyond the last entry read zero. Writes to any of them change no register.
- R10: Setting the mask bit of a pending pin withdraws its message at once, and clearing the mask again does not bring the message back.
- R11: An input held high for several cycles produces exactly one message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_en | input | 1 | Register bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset (0x00 index, 0x10 window) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_in | input | NUM_PINS | Edge-signalled interrupt inputs |
| msg_valid | output | 1 | A delivery message is offered |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_pin | output | PIN_W | Pin number of the message |
| msg_vector | output | 8 | Vector of the message |
| msg_mode | output | 3 | Delivery mode of the message |
| msg_logical | output | 1 | Destination addressing mode of the message |
| msg_dest | output | 8 | Destination of the message |

## Verification
Delivery is exercised with four patterns. A single pulse on an unmasked pin shows that the entry's fields reach the message. A pulse on a masked pin, followed by unmasking, tells dropping apart from deferring. A simultaneous pulse on three pins shows ascending service order and one completion per cycle. A level held high tells edge behaviour apart from level behaviour. A separate case masks a pending pin and then unmasks it, which tells withdrawal apart from a stale pending bit. The register vectors write all ones to every kind of index, so that writable bits can be told apart from reserved, read-only and unmapped bits.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam logic [7:0] OFS_SELECT = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;

  localparam logic [7:0] IDX_IDENT  = 8'h00;
  localparam logic [7:0] IDX_VER    = 8'h01;
  localparam logic [7:0] IDX_ARB    = 8'h02;
  localparam logic [7:0] IDX_TABLE  = 8'h10;

  // one redirection entry, only the implemented bits
  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       logical;
    logic [2:0] mode;
    logic [7:0] vector;
  } redir_t;

  localparam redir_t REDIR_RESET = '{dest: 8'h00, mask: 1'b1, logical: 1'b0,
                                     mode: 3'b000, vector: 8'h00};

  function automatic logic [31:0] low_word(redir_t e);
    return {15'b0, e.mask, 4'b0, e.logical, e.mode, e.vector};
  endfunction

  function automatic logic [31:0] high_word(redir_t e);
    return {e.dest, 24'b0};
  endfunction

endpackage

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned PIN_W    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     wr_hi,
  input  logic [PIN_W-1:0]         wr_pin,
  input  redir_t                   wr_ent,
  output redir_t [NUM_PINS-1:0]    tbl_o
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_entry
    redir_t ent_q;
    redir_t ent_d;
    logic   hit;

    assign hit = wr_en && (wr_pin == PIN_W'(p));

    always_comb begin
      ent_d = ent_q;
      if (wr_hi) begin
        ent_d.dest = wr_ent.dest;
      end else begin
        ent_d.vector  = wr_ent.vector;
        ent_d.mode    = wr_ent.mode;
        ent_d.logical = wr_ent.logical;
        ent_d.mask    = wr_ent.mask;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= REDIR_RESET;
      end else if (hit) begin
        ent_q <= ent_d;
      end
    end

    assign tbl_o[p] = ent_q;
  end

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned PIN_W    = 3,
  parameter logic [7:0]  VERSION  = 8'h11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [7:0]            bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  redir_t [NUM_PINS-1:0] tbl_i,
  output logic                  tbl_we,
  output logic                  tbl_hi,
  output logic [PIN_W-1:0]      tbl_pin,
  output redir_t                tbl_wdata,
  output logic [7:0]            sel_o
);

  localparam logic [8:0] TBL_SPAN = 9'(2 * NUM_PINS);
  localparam logic [7:0] TOP_PIN  = 8'(NUM_PINS - 1);

  logic [7:0]  sel_q, sel_d;
  logic [3:0]  id_q, id_d;
  logic        wr_sel, wr_win, id_we;
  logic [7:0]  entry_off;
  logic        in_table;
  logic [31:0] win_val;
  redir_t      cur_ent;
  logic        unused_wbits;

  assign wr_sel    = bus_en && bus_we && (bus_addr == OFS_SELECT);
  assign wr_win    = bus_en && bus_we && (bus_addr == OFS_WINDOW);

  assign entry_off = sel_q - IDX_TABLE;
  assign in_table  = (sel_q >= IDX_TABLE) && ({1'b0, entry_off} < TBL_SPAN);

  assign tbl_we    = wr_win && in_table;
  assign tbl_hi    = entry_off[0];
  assign tbl_pin   = entry_off[PIN_W:1];
  assign tbl_wdata = '{dest: bus_wdata[31:24], mask: bus_wdata[16],
                       logical: bus_wdata[11], mode: bus_wdata[10:8],
                       vector: bus_wdata[7:0]};
  assign unused_wbits = ^{bus_wdata[23:17], bus_wdata[15:12]};

  assign id_we = wr_win && (sel_q == IDX_IDENT);

  always_comb begin
    sel_d = wr_sel ? bus_wdata[7:0] : sel_q;
    id_d  = id_we ? bus_wdata[27:24] : id_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 8'h00;
    end else if (wr_sel) begin
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= 4'h0;
    end else if (id_we) begin
      id_q <= id_d;
    end
  end

  assign cur_ent = tbl_i[tbl_pin];

  always_comb begin
    win_val = 32'h0;
    if (in_table) begin
      win_val = tbl_hi ? high_word(cur_ent) : low_word(cur_ent);
    end else begin
      case (sel_q)
        IDX_IDENT, IDX_ARB: win_val = {4'h0, id_q, 24'h0};
        IDX_VER:            win_val = {8'h00, TOP_PIN, 8'h00, VERSION};
        default:            win_val = 32'h0;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_SELECT: bus_rdata = {24'h0, sel_q};
      OFS_WINDOW: bus_rdata = win_val;
      default:    bus_rdata = 32'h0;
    endcase
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned PIN_W    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   irq_in,
  input  redir_t [NUM_PINS-1:0] tbl_i,
  input  logic                  msg_ready,
  output logic                  msg_valid,
  output logic [PIN_W-1:0]      msg_pin,
  output logic [7:0]            msg_vector,
  output logic [2:0]            msg_mode,
  output logic                  msg_logical,
  output logic [7:0]            msg_dest
);

  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] pend_q, pend_d;
  logic [NUM_PINS-1:0] mask_vec, rise, cand, clr_vec;
  logic [PIN_W-1:0]    pick;
  logic                take;
  redir_t              pick_ent;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_mask
    assign mask_vec[p] = tbl_i[p].mask;
  end

  assign rise = irq_in & ~prev_q;
  assign cand = pend_q & ~mask_vec;

  // lowest-numbered candidate wins
  always_comb begin
    pick = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (cand[i]) pick = PIN_W'(i);
    end
  end

  assign msg_valid = |cand;
  assign take      = msg_valid && msg_ready;

  always_comb begin
    clr_vec       = '0;
    clr_vec[pick] = take;
    pend_d        = ((pend_q & ~clr_vec) | rise) & ~mask_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= irq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pick_ent    = tbl_i[pick];
  assign msg_pin     = pick;
  assign msg_vector  = pick_ent.vector;
  assign msg_mode    = pick_ent.mode;
  assign msg_logical = pick_ent.logical;
  assign msg_dest    = pick_ent.dest;

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter logic [7:0]  VERSION  = 8'h11,
  parameter int unsigned PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] irq_in,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [PIN_W-1:0]    msg_pin,
  output logic [7:0]          msg_vector,
  output logic [2:0]          msg_mode,
  output logic                msg_logical,
  output logic [7:0]          msg_dest
);

  logic [1:0]            rst_pipe_q;
  logic                  rst_n_i;
  redir_t [NUM_PINS-1:0] tbl;
  logic                  tbl_we, tbl_hi;
  logic [PIN_W-1:0]      tbl_pin;
  redir_t                tbl_wdata;
  logic [7:0]            sel_q;
  logic [NUM_PINS-1:0]   pin_masked;

  // reset asserts at once, releases two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_i = rst_pipe_q[1];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_mask
    assign pin_masked[p] = tbl[p].mask;
  end

  irq_route_regs #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W), .VERSION(VERSION)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tbl_i     (tbl),
    .tbl_we    (tbl_we),
    .tbl_hi    (tbl_hi),
    .tbl_pin   (tbl_pin),
    .tbl_wdata (tbl_wdata),
    .sel_o     (sel_q)
  );

  irq_route_table #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .wr_en  (tbl_we),
    .wr_hi  (tbl_hi),
    .wr_pin (tbl_pin),
    .wr_ent (tbl_wdata),
    .tbl_o  (tbl)
  );

  irq_route_arb #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .irq_in      (irq_in),
    .tbl_i       (tbl),
    .msg_ready   (msg_ready),
    .msg_valid   (msg_valid),
    .msg_pin     (msg_pin),
    .msg_vector  (msg_vector),
    .msg_mode    (msg_mode),
    .msg_logical (msg_logical),
    .msg_dest    (msg_dest)
  );

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned PIN_W    = 3,
  parameter logic [7:0]  VERSION  = 8'h11
) (
  input logic                clk,
  input logic                rst_n_i,
  input logic                bus_en,
  input logic                bus_we,
  input logic [7:0]          bus_addr,
  input logic [7:0]          wr_low,
  input logic [31:0]         bus_rdata,
  input logic [7:0]          sel_q,
  input logic [NUM_PINS-1:0] pin_masked,
  input logic [NUM_PINS-1:0] irq_in,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [PIN_W-1:0]    msg_pin
);

  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};

  a_r1_index_write: assert property (@(posedge clk) disable iff (!rst_n_i)
    (bus_en && bus_we && bus_addr == 8'h00) |=> (sel_q == $past(wr_low)));

  a_r3_version_value: assert property (@(posedge clk) disable iff (!rst_n_i)
    (bus_addr == 8'h10 && sel_q == 8'h01) |-> (bus_rdata == VER_WORD));

  a_r4_low_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n_i)
    (bus_addr == 8'h10 && sel_q >= 8'h10 && !sel_q[0])
      |-> (bus_rdata[31:17] == 15'h0 && bus_rdata[15:12] == 4'h0));

  a_r10_no_masked_offer: assert property (@(posedge clk) disable iff (!rst_n_i)
    msg_valid |-> !pin_masked[msg_pin]);

  a_r6_offer_needs_input: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(msg_valid) |-> $past(|irq_in));

  a_r11_single_delivery: assert property (@(posedge clk) disable iff (!rst_n_i)
    (msg_valid && msg_ready && !irq_in[msg_pin])
      |=> !(msg_valid && msg_pin == $past(msg_pin)));

endmodule

bind irq_route_ctrl irq_route_chk #(
  .NUM_PINS (NUM_PINS),
  .PIN_W    (PIN_W),
  .VERSION  (VERSION)
) u_chk (
  .clk        (clk),
  .rst_n_i    (rst_n_i),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .wr_low     (bus_wdata[7:0]),
  .bus_rdata  (bus_rdata),
  .sel_q      (sel_q),
  .pin_masked (pin_masked),
  .irq_in     (irq_in),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_pin    (msg_pin)
);

// File: tb/test_irq_route_ctrl.sv
module test_irq_route_ctrl;

  localparam int NP = 8;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_en, bus_we;
  logic [7:0]    bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NP-1:0] irq_in;
  logic          msg_valid, msg_ready, msg_logical;
  logic [PW-1:0] msg_pin;
  logic [7:0]    msg_vector, msg_dest;
  logic [2:0]    msg_mode;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  irq_route_ctrl #(.NUM_PINS(NP), .VERSION(8'h11)) i_irq_route_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_pin(msg_pin), .msg_vector(msg_vector), .msg_mode(msg_mode),
    .msg_logical(msg_logical), .msg_dest(msg_dest)
  );

  typedef struct packed {
    logic        rd;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0, 8'h00, 32'h0000_0001, 8'd1},
    '{1'b1, 8'h00, 32'h0000_0001, 8'd1},
    '{1'b1, 8'h10, 32'h0007_0011, 8'd3},
    '{1'b0, 8'h10, 32'hFFFF_FFFF, 8'd3},
    '{1'b1, 8'h10, 32'h0007_0011, 8'd3},
    '{1'b0, 8'h00, 32'h0000_0000, 8'd2},
    '{1'b0, 8'h10, 32'hFFFF_FFFF, 8'd2},
    '{1'b1, 8'h10, 32'h0F00_0000, 8'd2},
    '{1'b0, 8'h00, 32'h0000_0002, 8'd2},
    '{1'b1, 8'h10, 32'h0F00_0000, 8'd2},
    '{1'b0, 8'h10, 32'h0000_0000, 8'd2},
    '{1'b1, 8'h10, 32'h0F00_0000, 8'd2},
    '{1'b0, 8'h00, 32'h0000_0005, 8'd9},
    '{1'b0, 8'h10, 32'hFFFF_FFFF, 8'd9},
    '{1'b1, 8'h10, 32'h0000_0000, 8'd9},
    '{1'b0, 8'h00, 32'h0000_0013, 8'd4},
    '{1'b0, 8'h10, 32'hFFFF_FFFF, 8'd4},
    '{1'b1, 8'h10, 32'hFF00_0000, 8'd4},
    '{1'b0, 8'h00, 32'h0000_0012, 8'd4},
    '{1'b0, 8'h10, 32'hFFFF_FFFF, 8'd4},
    '{1'b1, 8'h10, 32'h0001_0FFF, 8'd4},
    '{1'b0, 8'h00, 32'h0000_0020, 8'd9},
    '{1'b0, 8'h10, 32'hFFFF_FFFF, 8'd9},
    '{1'b1, 8'h10, 32'h0000_0000, 8'd9},
    '{1'b1, 8'h04, 32'h0000_0000, 8'd9},
    '{1'b0, 8'h04, 32'h0000_0055, 8'd9},
    '{1'b1, 8'h00, 32'h0000_0020, 8'd9}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic prog(input int p, input logic [31:0] lo, input logic [31:0] hi);
    bwr(8'h00, 32'(8'h10 + 2 * p));
    bwr(8'h10, lo);
    bwr(8'h00, 32'(8'h10 + 2 * p + 1));
    bwr(8'h10, hi);
  endtask

  // one-cycle pulse; returns at the negedge after the capturing posedge
  task automatic pulse(input logic [NP-1:0] m);
    @(negedge clk);
    irq_in = irq_in | m;
    @(negedge clk);
    irq_in = irq_in & ~m;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int          cnt;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = 8'h00;
    bus_wdata = 32'h0; irq_in = '0; msg_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5: reset state
    brd(8'h00, rd); check("R5 index", rd, 32'h0);
    bwr(8'h00, 32'h0); brd(8'h10, rd); check("R5 ident", rd, 32'h0);
    for (int p = 0; p < NP; p++) begin
      bwr(8'h00, 32'(8'h10 + 2 * p)); brd(8'h10, rd); check("R5 low word", rd, 32'h0001_0000);
      bwr(8'h00, 32'(8'h11 + 2 * p)); brd(8'h10, rd); check("R5 high word", rd, 32'h0);
    end
    check("R5 no message", 32'(msg_valid), 32'h0);

    // register vectors R1 R2 R3 R4 R9
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) begin
        brd(VEC[i].addr, rd);
        check($sformatf("R%0d vector %0d", VEC[i].req, i), rd, VEC[i].data);
      end else begin
        bwr(VEC[i].addr, VEC[i].data);
      end
    end

    // R6: single delivery with fields
    prog(1, 32'h0000_0C41, 32'h5A00_0000);
    pulse(8'b0000_0010);
    #1;
    check("R6 valid", 32'(msg_valid), 32'h1);
    check("R6 pin", 32'(msg_pin), 32'h1);
    check("R6 vector", 32'(msg_vector), 32'h41);
    check("R6 mode", 32'(msg_mode), 32'h4);
    check("R6 logical", 32'(msg_logical), 32'h1);
    check("R6 dest", 32'(msg_dest), 32'h5A);
    msg_ready = 1'b1;
    @(negedge clk); #1;
    check("R6 withdrawn after handshake", 32'(msg_valid), 32'h0);

    // R11: held level gives one message
    @(negedge clk);
    irq_in[1] = 1'b1;
    cnt = 0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk); #1;
      if (msg_valid && msg_ready) cnt++;
    end
    irq_in[1] = 1'b0;
    check("R11 one message per level", 32'(cnt), 32'h1);

    // R7: masked edge dropped
    prog(2, 32'h0001_0042, 32'h0);
    pulse(8'b0000_0100);
    #1 check("R7 masked no message", 32'(msg_valid), 32'h0);
    bwr(8'h00, 32'h14); bwr(8'h10, 32'h0000_0042);
    repeat (3) @(negedge clk);
    #1 check("R7 not delivered after unmask", 32'(msg_valid), 32'h0);

    // R8: ascending order
    msg_ready = 1'b0;
    prog(0, 32'h50, 32'h0);
    prog(3, 32'h53, 32'h0);
    prog(5, 32'h55, 32'h0);
    pulse(8'b0010_1001);
    #1;
    check("R8 first pin", 32'(msg_pin), 32'h0);
    check("R8 first vector", 32'(msg_vector), 32'h50);
    msg_ready = 1'b1;
    @(negedge clk); #1;
    check("R8 second pin", 32'(msg_pin), 32'h3);
    check("R8 second vector", 32'(msg_vector), 32'h53);
    @(negedge clk); #1;
    check("R8 third pin", 32'(msg_pin), 32'h5);
    check("R8 third valid", 32'(msg_valid), 32'h1);
    @(negedge clk); #1;
    check("R8 drained", 32'(msg_valid), 32'h0);
    msg_ready = 1'b0;

    // R10: mask withdraws a pending pin
    pulse(8'b0000_1000);
    #1 check("R10 pending offered", 32'(msg_pin), 32'h3);
    check("R10 pending valid", 32'(msg_valid), 32'h1);
    bwr(8'h00, 32'h16); bwr(8'h10, 32'h0001_0053);
    #1 check("R10 withdrawn by mask", 32'(msg_valid), 32'h0);
    bwr(8'h10, 32'h0000_0053);
    repeat (2) @(negedge clk);
    #1 check("R10 not back after unmask", 32'(msg_valid), 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule